// File: doc/BRIEF.md
# Receive Byte FIFO with Per-Byte Error Tallies

This block stores bytes arriving from a serial receiver. Each byte is kept with two tag bits: one marks a parity error, one marks a framing error. Bytes leave in arrival order, and each byte comes out together with its two tags. Two 6-bit tallies always reflect the bytes currently held. One tally counts bytes tagged with a parity error and the other counts bytes tagged with a framing error. A tally rises when a tagged byte enters and falls when a tagged byte leaves. Software reads both tallies through one read-only 16-bit status word.

The receiver drives the write side with a byte and its tags. The consumer takes the oldest byte through the read side, which shows the head entry whenever the FIFO is not empty. The tallies are meant to be read once the receiver's error summary is set. A single-cycle input reports that event, and the block keeps it as a sticky qualifier. A synchronous clear input empties the store and zeroes both tallies in one cycle.

Top module: `rx_err_fifo`

## Requirements
- R1: After reset the FIFO is empty, `level` is 0, `err_status` is 0, and `overrun` and `stat_valid` are 0.
- R2: Bytes leave in the order they were written. While the FIFO is not empty, `rd_data`, `rd_perr` and `rd_ferr` together show the oldest stored byte and its two tags.
- R3: `full` is 1 when 64 bytes are held. A write while full is dropped, even if a read happens in the same cycle. The dropped write sets `overrun`, which stays 1 until clear or reset, and it leaves `level` and both tallies unchanged.
- R4: A read while empty is ignored. `level` stays 0 and `err_status` stays 0.
- R5: `err_status[13:8]` equals the number of stored bytes tagged with a parity error, modulo 64.
- R6: `err_status[5:0]` equals the number of stored bytes tagged with a framing error, modulo 64.
- R7: `err_status[15:14]` and `err_status[7:6]` always read 0.
- R8: A write and a read accepted in the same cycle leave `level` unchanged. Each tally changes by the incoming tag minus the outgoing tag.
- R9: When all 64 stored bytes carry a parity error, `err_status[13:8]` reads 0. The framing field follows the same rule.
- R10: `clr` empties the FIFO and zeroes both tallies, `overrun` and `stat_valid` on the next edge. A write or read in the same cycle is ignored.
- R11: A one-cycle pulse on `err_set` sets `stat_valid` on the next edge. `stat_valid` stays set until clear or reset, and clear wins if both occur in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of store, tallies and flags |
| wr_en | input | 1 | Write request |
| wr_data | input | 8 | Received byte |
| wr_perr | input | 1 | Parity error tag of the byte |
| wr_ferr | input | 1 | Framing error tag of the byte |
| rd_en | input | 1 | Read (pop) request |
| rd_data | output | 8 | Oldest stored byte |
| rd_perr | output | 1 | Parity tag of the oldest byte |
| rd_ferr | output | 1 | Framing tag of the oldest byte |
| empty | output | 1 | No bytes held |
| full | output | 1 | 64 bytes held |
| level | output | 7 | Number of bytes held |
| overrun | output | 1 | Sticky: a write was dropped while full |
| err_set | input | 1 | Pulse: receiver error summary became set |
| stat_valid | output | 1 | Sticky qualifier for the tallies |
| err_status | output | 16 | Read-only tallies word |

## Verification
A tally that drifts from the stored tags shows in `err_status` on the very edge that pushed or popped the byte. It is caught in that cycle, because every field is compared each clock against a queue model. Pointer faults show up as a wrong head byte or wrong tags at `rd_data` as soon as the affected entry reaches the head. They also show as a `level` mismatch. The 64-entry wrap and the dropped write on a full FIFO are driven deliberately, so that a zero in a full tally and an unchanged word after overflow are both checked.

// File: rtl/rx_err_fifo.sv
module rx_err_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     wr_en,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic                     wr_perr,
  input  logic                     wr_ferr,
  input  logic                     rd_en,
  output logic [DATA_W-1:0]        rd_data,
  output logic                     rd_perr,
  output logic                     rd_ferr,
  output logic                     empty,
  output logic                     full,
  output logic [$clog2(DEPTH):0]   level,
  output logic                     overrun,
  input  logic                     err_set,
  output logic                     stat_valid,
  output logic [15:0]              err_status
);
  localparam int AW  = $clog2(DEPTH);
  localparam int EW  = DATA_W + 2;
  localparam int PAD = 8 - AW;

  logic [EW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr, pcnt, fcnt;
  logic [AW:0]   cnt;
  logic          push, pop;
  logic [EW-1:0] head;

  assign full  = cnt == (AW+1)'(DEPTH);
  assign empty = cnt == '0;
  assign push  = wr_en && !full && !clr;
  assign pop   = rd_en && !empty && !clr;
  assign head  = mem[rptr];
  assign {rd_perr, rd_ferr, rd_data} = head;
  assign level = cnt;
  assign err_status = {{PAD{1'b0}}, pcnt, {PAD{1'b0}}, fcnt};

  always_ff @(posedge clk)
    if (push) mem[wptr] <= {wr_perr, wr_ferr, wr_data};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      cnt <= '0;
      pcnt <= '0;
      fcnt <= '0;
      overrun <= 1'b0;
      stat_valid <= 1'b0;
    end else if (clr) begin
      wptr <= '0;
      rptr <= '0;
      cnt <= '0;
      pcnt <= '0;
      fcnt <= '0;
      overrun <= 1'b0;
      stat_valid <= 1'b0;
    end else begin
      if (push) wptr <= wptr + 1'b1;
      if (pop)  rptr <= rptr + 1'b1;
      cnt  <= cnt + (AW+1)'(push) - (AW+1)'(pop);
      pcnt <= pcnt + AW'(push && wr_perr) - AW'(pop && head[EW-1]);
      fcnt <= fcnt + AW'(push && wr_ferr) - AW'(pop && head[EW-2]);
      if (wr_en && full) overrun <= 1'b1;
      if (err_set) stat_valid <= 1'b1;
    end
  end

  p_level_max_r3: assert property (@(posedge clk) disable iff (!rst_n)
    level <= (AW+1)'(DEPTH));

  p_full_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    full && wr_en && !rd_en && !clr |=> full && overrun && err_status == $past(err_status));

  p_overrun_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    overrun && !clr |=> overrun);

  p_empty_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    empty && rd_en && !wr_en |=> empty && err_status == 16'h0);

  p_empty_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> err_status == 16'h0);

  p_pair_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && rd_en && !full && !empty && !clr |=> $stable(level));

  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> empty && err_status == 16'h0 && !overrun && !stat_valid);

  p_valid_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
    err_set && !clr |=> stat_valid);
endmodule

// File: tb/sim_rx_err_fifo.sv
module sim_rx_err_fifo;
  logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0;
  logic wr_en = 1'b0, wr_perr = 1'b0, wr_ferr = 1'b0, rd_en = 1'b0, err_set = 1'b0;
  logic [7:0] wr_data = 8'h0;
  logic [7:0] rd_data;
  logic rd_perr, rd_ferr, empty, full, overrun, stat_valid;
  logic [6:0] level;
  logic [15:0] err_status;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [9:0] q[$];
  bit m_ov = 0, m_sv = 0;

  always #5 clk = ~clk;

  rx_err_fifo u0 (.clk(clk), .rst_n(rst_n), .clr(clr), .wr_en(wr_en), .wr_data(wr_data),
    .wr_perr(wr_perr), .wr_ferr(wr_ferr), .rd_en(rd_en), .rd_data(rd_data),
    .rd_perr(rd_perr), .rd_ferr(rd_ferr), .empty(empty), .full(full), .level(level),
    .overrun(overrun), .err_set(err_set), .stat_valid(stat_valid), .err_status(err_status));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compare();
    int np = 0, nf = 0;
    foreach (q[i]) begin
      np += int'(q[i][9]);
      nf += int'(q[i][8]);
    end
    chk(int'(level) == q.size(), "R3 level", int'(level), q.size());
    chk(full == (q.size() == 64), "R3 full", int'(full), int'(q.size() == 64));
    chk(empty == (q.size() == 0), "R4 empty", int'(empty), int'(q.size() == 0));
    chk(overrun == m_ov, "R3 overrun", int'(overrun), int'(m_ov));
    chk(stat_valid == m_sv, "R11 stat_valid", int'(stat_valid), int'(m_sv));
    chk(int'(err_status[13:8]) == np % 64, "R5 parity tally", int'(err_status[13:8]), np % 64);
    chk(int'(err_status[5:0]) == nf % 64, "R6 framing tally", int'(err_status[5:0]), nf % 64);
    chk(err_status[15:14] == 2'b0 && err_status[7:6] == 2'b0, "R7 reserved", int'(err_status), 0);
    if (q.size() > 0)
      chk({rd_perr, rd_ferr, rd_data} == q[0], "R2 head", int'({rd_perr, rd_ferr, rd_data}), int'(q[0]));
  endtask

  task automatic step(input bit w, input logic [7:0] d, input bit pe, input bit fe,
                      input bit r, input bit c, input bit e);
    bit pok, rok;
    @(negedge clk);
    compare();
    wr_en = w; wr_data = d; wr_perr = pe; wr_ferr = fe; rd_en = r; clr = c; err_set = e;
    pok = w && q.size() < 64;
    rok = r && q.size() > 0;
    if (c) begin
      q.delete(); m_ov = 0; m_sv = 0;
    end else begin
      if (rok) void'(q.pop_front());
      if (pok) q.push_back({pe, fe, d});
      if (w && !pok) m_ov = 1;
      if (e) m_sv = 1;
    end
  endtask

  task automatic idle();
    step(0, 8'h0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int lv;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(empty && level == 0 && err_status == 0 && !overrun && !stat_valid, "R1 reset state",
        int'(err_status), 0);

    for (int i = 0; i < 5; i++) step(1, 8'h10 + 8'(i), i[0], i[1], 0, 0, 0);
    step(0, 8'h0, 0, 0, 0, 0, 1);
    for (int i = 0; i < 3; i++) step(0, 8'h0, 0, 0, 1, 0, 0);
    idle();
    lv = int'(level);
    for (int i = 0; i < 4; i++) step(1, 8'h40 + 8'(i), 1, i[0], 1, 0, 0);
    idle();
    chk(int'(level) == lv, "R8 paired push/pop level", int'(level), lv);
    for (int i = 0; i < 6; i++) step(0, 8'h0, 0, 0, 1, 0, 0);
    idle();
    chk(empty && err_status == 0, "R4 pop on empty ignored", int'(err_status), 0);

    step(0, 8'h0, 0, 0, 0, 1, 0);
    idle();
    for (int i = 0; i < 64; i++) step(1, 8'(i * 3), 1, 1, 0, 0, 0);
    idle();
    chk(full && err_status[13:8] == 0, "R9 parity tally wraps", int'(err_status[13:8]), 0);
    chk(err_status[5:0] == 0, "R9 framing tally wraps", int'(err_status[5:0]), 0);
    step(1, 8'hAA, 0, 0, 0, 0, 0);
    step(1, 8'hBB, 0, 1, 1, 0, 0);
    idle();
    chk(overrun && level == 63, "R3 drop on full", int'(level), 63);
    for (int i = 0; i < 10; i++) step(1, 8'(i), 0, i[0], 1, 0, 1);
    step(1, 8'h77, 1, 1, 1, 1, 1);
    idle();
    chk(empty && err_status == 0 && !overrun && !stat_valid, "R10 clear", int'(err_status), 0);

    for (int i = 0; i < 3000; i++) begin
      int u;
      u = $urandom;
      step(u[0] | u[1], 8'(u >> 8), u[2], u[3], u[4] & (u[5] | u[6]),
           (u[20:12] == 0), (u[27:23] == 0));
    end
    for (int i = 0; i < 70; i++) step(1, 8'(i), i[1], i[2], 0, 0, 0);
    for (int i = 0; i < 70; i++) step(0, 8'h0, 0, 0, 1, 0, 0);
    idle();
    idle();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule